// File: doc/BRIEF.md
# Dual-Clock FIFO with Level Threshold Flags

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. It holds 9-bit words, eight data bits plus a parity bit. The number of usable slots is chosen at run time by a 3-bit depth code, from 2 up to the size of the storage array. The write side raises a full flag, and further writes are then refused. The read side raises an empty flag, and further reads are then refused. Pointers cross between the clock domains in Gray code through two-flop synchronisers.

The write side also compares the number of stored words with an 8-bit threshold. It gives one flag for an exact match and one for "at or above". When storage is deeper than 256 words, the threshold is scaled up by the matching power of two. Parity can be produced on the way in, in which case bit 8 is replaced by a computed parity bit. Parity is checked on incoming words when generation is off and on every word read out. One select input chooses odd or even parity for both generation and checking. Strobes, block selects and the reset are active-low.

The reset is sampled synchronously by each clock. It clears the pointers, the flags and the read data register. It leaves the storage array untouched. The depth code and the parity controls are meant to be static while traffic flows. The depth code should change only while reset is held.

Top module: `lvl_fifo`

## Requirements
- R1: A write takes place at a wr_clk rising edge only when wr_sel_n and wr_stb_n are both 0 and full is 0. A read takes place at an rd_clk rising edge only when rd_sel_n and rd_stb_n are both 0 and empty is 0. A refused write or read changes no stored word, no pointer and no output data.
- R2: The capacity is 2^(depth_code+1) words, limited to the array size. full reads 1 exactly when that many words are held, as seen by the write side.
- R3: Words leave in the order they were written. rd_data takes the next word at the rd_clk edge that accepts a read, and holds it otherwise.
- R4: empty reads 1 when the read side sees no stored word. After a write into an empty FIFO it clears within three rd_clk edges.
- R5: lvl_eq is 1 when the stored word count seen by the write side equals the threshold. It is registered, so it trails the count by one wr_clk.
- R6: lvl_geq is 1 when that count is greater than or equal to the threshold. The threshold is shifted left by (array address bits − 8) when the array is deeper than 256 words. With a count of 0 and a threshold of 0, both flags read 1.
- R7: With par_gen at 1, bit 8 of the stored word is computed from bits 7:0. The 9-bit word then has an odd number of ones when par_odd is 1, and an even number when par_odd is 0.
- R8: With par_gen at 0, an accepted write whose 9-bit word has a ones-count parity other than the one par_odd selects raises wr_perr for the one wr_clk cycle after that write. wr_perr stays 0 for refused writes and whenever par_gen is 1.
- R9: After the first accepted read, rd_perr is 1 exactly while rd_data's ones-count parity differs from the one par_odd selects.
- R10: While rst_n is 0, the pointers clear at each clock's edges. Then empty reads 1, full reads 0, rd_data reads 0, and rd_perr and wr_perr read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled by both clocks |
| depth_code | input | 3 | Capacity code, depth = 2^(code+1) |
| thresh | input | 8 | Fill level threshold |
| par_gen | input | 1 | 1: replace bit 8 with computed parity on write |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| wr_sel_n | input | 1 | Write block select, active-low |
| wr_stb_n | input | 1 | Write strobe, active-low |
| wr_data | input | 9 | Incoming word |
| rd_sel_n | input | 1 | Read block select, active-low |
| rd_stb_n | input | 1 | Read strobe, active-low |
| rd_data | output | 9 | Registered outgoing word |
| full | output | 1 | No room, writes refused |
| empty | output | 1 | Nothing stored, reads refused |
| lvl_eq | output | 1 | Count equals threshold |
| lvl_geq | output | 1 | Count at or above threshold |
| wr_perr | output | 1 | Parity mismatch on an accepted incoming word |
| rd_perr | output | 1 | Parity mismatch on the word held in rd_data |

## Verification
Each result has its own latency:
- rd_data and rd_perr: due at the rd_clk edge that accepts the read.
- full: due at the wr_clk edge of the write that fills the FIFO.
- wr_perr: due at the wr_clk edge after the write.
- empty: clears within three rd_clk edges after a write.
- Threshold flags: settle two wr_clk edges after a write, and about five wr_clk edges after a read, because the read pointer must first cross the domain boundary.

The bench drives and samples on falling edges, so rd_data and wr_perr are read half a cycle after the edge that produces them. Before it compares full, empty or the threshold flags with its reference count, it waits eight cycles of each clock. The concurrent streaming phase checks only data order, because flag timing across domains is not exact there.

// File: rtl/lvlf_pkg.sv
package lvlf_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 1;

  typedef logic [WORD_W-1:0] word_t;

  // parity bit that makes {bit, d} carry odd (odd=1) or even (odd=0) ones
  function automatic logic par_bit(input logic [BYTE_W-1:0] d, input logic odd);
    return odd ? ~(^d) : (^d);
  endfunction

  // 1 when the whole word matches the selected parity
  function automatic logic word_par_ok(input word_t w, input logic odd);
    return (^w) == odd;
  endfunction
endpackage

// File: rtl/lvlf_gray_xing.sv
module lvlf_gray_xing #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stg1, stg2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= gray_in;
      stg2 <= stg1;
    end
  end

  // gray to binary: each bit is the xor of all gray bits at or above it
  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^(stg2 >> i);
  end
endmodule

// File: rtl/lvlf_ram.sv
module lvlf_ram #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // storage is never cleared by reset
  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port with synchronous output reset
  always_ff @(posedge rclk) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/lvlf_wr_ctl.sv
module lvlf_wr_ctl
  import lvlf_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          stb_n,
  input  word_t         din,
  input  logic [LW-1:0] lg,
  input  logic [7:0]    thresh,
  input  logic          par_gen,
  input  logic          par_odd,
  input  logic [AW:0]   rptr_s,
  output logic [AW:0]   wptr_g,
  output logic [AW-1:0] waddr,
  output logic          we,
  output word_t         wdata,
  output logic          full,
  output logic          lvl_eq,
  output logic          lvl_geq,
  output logic          perr
);
  localparam int CW = AW + 1;

  logic [CW-1:0] wptr, wnext, count, depth_w, thr_eff;
  logic [AW-1:0] msk;
  logic          req;

  always_comb begin
    depth_w = CW'(1) << lg;
    msk     = AW'(depth_w - CW'(1));
    count   = wptr - rptr_s;
    wnext   = wptr + CW'(1);
  end

  // threshold scaling for arrays deeper than 256 words
  if (AW > 8) begin : g_thr_scaled
    assign thr_eff = {1'b0, thresh, {(AW-8){1'b0}}};
  end else begin : g_thr_plain
    assign thr_eff = CW'(thresh);
  end

  assign req   = ~sel_n & ~stb_n;
  assign full  = (count >= depth_w);
  assign we    = req & ~full;
  assign waddr = wptr[AW-1:0] & msk;
  assign wdata = {(par_gen ? par_bit(din[7:0], par_odd) : din[8]), din[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      wptr_g  <= '0;
      lvl_eq  <= 1'b0;
      lvl_geq <= 1'b0;
      perr    <= 1'b0;
    end else begin
      if (we) begin
        wptr   <= wnext;
        wptr_g <= wnext ^ (wnext >> 1);
      end
      lvl_eq  <= (count == thr_eff);
      lvl_geq <= (count >= thr_eff);
      perr    <= we & ~par_gen & ~word_par_ok(din, par_odd);
    end
  end

  // R1: a write request while full leaves the write pointer alone
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (req && full) |=> (wptr == $past(wptr)));

  // R2: the write side never counts more words than the selected depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth_w);

  // R8: no write parity error follows a cycle without an accepted write
  a_r8_perr_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> !perr);
endmodule

// File: rtl/lvlf_rd_ctl.sv
module lvlf_rd_ctl
  import lvlf_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          stb_n,
  input  logic [LW-1:0] lg,
  input  logic          par_odd,
  input  logic [AW:0]   wptr_s,
  input  word_t         q,
  output logic [AW:0]   rptr_g,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic          empty,
  output logic          rd_perr
);
  localparam int CW = AW + 1;

  logic [CW-1:0] rptr, rnext, depth_r;
  logic [AW-1:0] msk;
  logic          req, rvalid;

  always_comb begin
    depth_r = CW'(1) << lg;
    msk     = AW'(depth_r - CW'(1));
    rnext   = rptr + CW'(1);
  end

  assign req     = ~sel_n & ~stb_n;
  assign empty   = (rptr == wptr_s);
  assign re      = req & ~empty;
  assign raddr   = rptr[AW-1:0] & msk;
  assign rd_perr = rvalid & ~word_par_ok(q, par_odd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr   <= '0;
      rptr_g <= '0;
      rvalid <= 1'b0;
    end else if (re) begin
      rptr   <= rnext;
      rptr_g <= rnext ^ (rnext >> 1);
      rvalid <= 1'b1;
    end
  end

  // R1: a read request while empty moves neither pointer nor data
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (req && empty) |=> (rptr == $past(rptr) && $stable(q)));

  // R10: one edge of reset leaves the read side empty with zero data
  a_r10_reset_state: assert property (@(posedge clk)
    !rst_n |=> (empty && q == '0 && !rd_perr));

  // R3: output data only changes after an accepted read
  a_r3_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(q));
endmodule

// File: rtl/lvl_fifo.sv
module lvl_fifo
  import lvlf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic        wr_clk,
  input  logic        rd_clk,
  input  logic        rst_n,
  input  logic [2:0]  depth_code,
  input  logic [7:0]  thresh,
  input  logic        par_gen,
  input  logic        par_odd,
  input  logic        wr_sel_n,
  input  logic        wr_stb_n,
  input  logic [8:0]  wr_data,
  input  logic        rd_sel_n,
  input  logic        rd_stb_n,
  output logic [8:0]  rd_data,
  output logic        full,
  output logic        empty,
  output logic        lvl_eq,
  output logic        lvl_geq,
  output logic        wr_perr,
  output logic        rd_perr
);
  localparam int CW = AW + 1;
  localparam int LW = $clog2(AW + 1);

  logic [3:0]    code_p1;
  logic [LW-1:0] lg;
  logic [CW-1:0] wptr_g, rptr_g, wptr_s, rptr_s;
  logic [AW-1:0] waddr, raddr;
  logic          we, re;
  word_t         wdata;

  // log2 of the selected depth, capped at the array size
  assign code_p1 = {1'b0, depth_code} + 4'd1;
  assign lg      = (int'(code_p1) > AW) ? LW'(AW) : LW'(code_p1);

  lvlf_wr_ctl #(.AW(AW), .LW(LW)) u_wr (
    .clk     (wr_clk),
    .rst_n   (rst_n),
    .sel_n   (wr_sel_n),
    .stb_n   (wr_stb_n),
    .din     (wr_data),
    .lg      (lg),
    .thresh  (thresh),
    .par_gen (par_gen),
    .par_odd (par_odd),
    .rptr_s  (rptr_s),
    .wptr_g  (wptr_g),
    .waddr   (waddr),
    .we      (we),
    .wdata   (wdata),
    .full    (full),
    .lvl_eq  (lvl_eq),
    .lvl_geq (lvl_geq),
    .perr    (wr_perr)
  );

  lvlf_gray_xing #(.W(CW)) u_w2r (
    .clk     (rd_clk),
    .rst_n   (rst_n),
    .gray_in (wptr_g),
    .bin_out (wptr_s)
  );

  lvlf_gray_xing #(.W(CW)) u_r2w (
    .clk     (wr_clk),
    .rst_n   (rst_n),
    .gray_in (rptr_g),
    .bin_out (rptr_s)
  );

  lvlf_ram #(.AW(AW), .DW(WORD_W)) u_ram (
    .wclk  (wr_clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .rclk  (rd_clk),
    .rst_n (rst_n),
    .re    (re),
    .raddr (raddr),
    .q     (rd_data)
  );

  lvlf_rd_ctl #(.AW(AW), .LW(LW)) u_rd (
    .clk     (rd_clk),
    .rst_n   (rst_n),
    .sel_n   (rd_sel_n),
    .stb_n   (rd_stb_n),
    .lg      (lg),
    .par_odd (par_odd),
    .wptr_s  (wptr_s),
    .q       (rd_data),
    .rptr_g  (rptr_g),
    .raddr   (raddr),
    .re      (re),
    .empty   (empty),
    .rd_perr (rd_perr)
  );
endmodule

// File: tb/lvl_fifo_tb.sv
`timescale 1ns/1ps
module lvl_fifo_tb;
  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic [2:0] depth_code = 3'd0;
  logic [7:0] thresh = 8'd0;
  logic       par_gen = 1'b0, par_odd = 1'b0;
  logic       wr_sel_n = 1'b1, wr_stb_n = 1'b1, rd_sel_n = 1'b1, rd_stb_n = 1'b1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       full, empty, lvl_eq, lvl_geq, wr_perr, rd_perr;

  int errs = 0, checks = 0, depth_m = 2;
  logic [8:0] q_m[$];
  bit done = 0;

  always #5   wr_clk = ~wr_clk;   // 100 MHz write clock
  always #7.3 rd_clk = ~rd_clk;   // unrelated read clock

  lvl_fifo u_dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] stored(input logic [8:0] d);
    if (par_gen) return {(par_odd ? ~(^d[7:0]) : (^d[7:0])), d[7:0]};
    return d;
  endfunction

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic do_reset(input logic [2:0] code);
    rst_n = 1'b0;
    depth_code = code;
    depth_m = 1 << (code + 1);
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    rst_n = 1'b1;
    q_m.delete();
    settle();
  endtask

  task automatic check_flags(input string tag);
    int n = q_m.size();
    chk("R2", {tag, " full"}, int'(full), int'(n == depth_m));
    chk("R4", {tag, " empty"}, int'(empty), int'(n == 0));
    chk("R5", {tag, " lvl_eq"}, int'(lvl_eq), int'(n == int'(thresh)));
    chk("R6", {tag, " lvl_geq"}, int'(lvl_geq), int'(n >= int'(thresh)));
  endtask

  // one write; settled mode accepts from the model count, stream mode from full
  task automatic wr_one(input logic [8:0] d, input bit stream);
    bit acc;
    @(negedge wr_clk);
    acc = stream ? !full : (q_m.size() < depth_m);
    if (acc) q_m.push_back(stored(d));
    wr_data = d; wr_sel_n = 1'b0; wr_stb_n = 1'b0;
    @(negedge wr_clk);
    wr_sel_n = 1'b1; wr_stb_n = 1'b1;
    if (!stream)
      chk("R8", "wr_perr", int'(wr_perr),
          int'(acc && !par_gen && ((^d) != par_odd)));
  endtask

  task automatic rd_one(input bit stream);
    bit acc;
    logic [8:0] exp;
    @(negedge rd_clk);
    acc = stream ? !empty : (q_m.size() > 0);
    exp = rd_data;
    if (acc) exp = q_m.pop_front();
    rd_sel_n = 1'b0; rd_stb_n = 1'b0;
    @(negedge rd_clk);
    rd_sel_n = 1'b1; rd_stb_n = 1'b1;
    chk(acc ? "R3" : "R1", "rd_data", int'(rd_data), int'(exp));
    if (acc) chk("R9", "rd_perr", int'(rd_perr), int'((^exp) != par_odd));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R10 reset state, threshold 0 with empty FIFO
    do_reset(3'd0);
    chk("R10", "empty", int'(empty), 1);
    chk("R10", "full", int'(full), 0);
    chk("R10", "rd_data", int'(rd_data), 0);
    chk("R10", "rd_perr", int'(rd_perr), 0);
    chk("R10", "wr_perr", int'(wr_perr), 0);
    chk("R6", "eq at 0", int'(lvl_eq), 1);
    chk("R6", "geq at 0", int'(lvl_geq), 1);

    // R2 R5 R6 R7: sweep small depths with generated parity
    for (int code = 0; code < 4; code++) begin
      par_gen = 1'b1;
      par_odd = code[0];
      thresh = 8'(1 << code);
      do_reset(3'(code));
      for (int k = 0; k <= depth_m; k++) begin
        wr_one(9'(((k * 37 + code * 11) & 8'hFF) | ((k & 1) << 8)), 1'b0);
        settle();
        check_flags("sweep wr");
      end
      for (int k = 0; k <= depth_m; k++) begin
        rd_one(1'b0);
        chk("R7", "word parity", int'(^rd_data), int'(par_odd));
        settle();
        check_flags("sweep rd");
      end
    end

    // R2 R5 R6: full-size array, threshold 255
    par_gen = 1'b0; par_odd = 1'b0; thresh = 8'd255;
    do_reset(3'd7);
    for (int k = 0; k < 255; k++) wr_one({^(8'(k)), 8'(k)}, 1'b0);
    settle(); check_flags("deep 255");
    wr_one({1'b0, 8'h00}, 1'b0);
    settle(); check_flags("deep 256");
    wr_one({1'b1, 8'h01}, 1'b0);
    settle(); check_flags("deep extra");
    for (int k = 0; k < 257; k++) rd_one(1'b0);
    settle(); check_flags("deep drained");

    // R8 R9: injected parity errors with generation off, odd parity
    par_gen = 1'b0; par_odd = 1'b1; thresh = 8'd3;
    do_reset(3'd2);
    for (int k = 0; k < 6; k++)
      wr_one({((^(8'(k * 29))) ^ k[0]), 8'(k * 29)}, 1'b0);
    settle(); check_flags("perr fill");
    for (int k = 0; k < 6; k++) rd_one(1'b0);
    settle(); check_flags("perr drained");

    // R1 R3: concurrent streaming across unrelated clocks
    par_gen = 1'b1; par_odd = 1'b1; thresh = 8'd8;
    do_reset(3'd3);
    fork
      for (int k = 0; k < 60; k++) begin
        while (full) @(negedge wr_clk);
        wr_one(9'(k * 13), 1'b1);
      end
      begin
        int got = 0;
        while (got < 60) begin
          @(negedge rd_clk);
          if (!empty) begin rd_one(1'b1); got++; end
        end
      end
    join
    settle(); check_flags("stream end");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule